// File: doc/BRIEF.md
# Segmented Address Translator with Privilege Checks

This block turns a segmented logical address (a 16-bit selector plus a 32-bit offset) into a 32-bit linear address. It also decides whether the access is allowed. It holds two small on-chip descriptor tables, one for segments shared by every process and one for the current process only. Each descriptor holds a base, a limit, a required privilege level and a present flag. Software fills the tables through a one-cycle write port.

A request is presented for one cycle with the caller's current privilege level and a flag that marks a privileged operation. One cycle later the block returns a valid strobe, a fault code and the linear address. The block checks for a privileged operation outside level 0, a missing descriptor, insufficient privilege and an offset beyond the limit, in that priority order. When translation is switched off, the offset passes through unchanged. In that mode the privileged-operation trap still applies.

Top module: `segx_top`

## Requirements
- R1: After reset, out_valid, out_fault and out_lin are all 0, and every descriptor in both tables is not present.
- R2: Selector layout: bits [1:0] are the requested level, bit 2 picks the table (0 = shared, 1 = per-process), and bits [15:3] are the index. An index at or beyond the table depth (default 8) gives fault code 2.
- R3: out_valid is 1 in exactly the cycle after a cycle with req_valid = 1, and 0 otherwise.
- R4: A request with req_priv_op = 1 and req_cpl != 0 gives fault code 1. This holds whether translation is on or off.
- R5: A selected descriptor whose present flag is 0 gives fault code 2.
- R6: With translation on, the effective level is the larger of req_cpl and the requested level. If it is numerically above the descriptor's required level, the fault code is 3.
- R7: An offset above the descriptor limit gives fault code 4. An offset equal to the limit is allowed.
- R8: A request with no fault returns fault code 0 and out_lin = base + offset modulo 2^32.
- R9: Whenever out_fault is nonzero, out_lin is 0.
- R10: With seg_en = 0 and no privileged-operation fault, out_lin equals the offset and the fault code is 0, whatever the table contents.
- R11: A write stores the descriptor in the table chosen by wr_local at wr_idx. Requests from the next cycle on see it. A request in the same cycle as the write sees the old entry. The two tables are independent.
- R12: When several faults apply, the lowest nonzero code from the order 1, 2, 3, 4 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_en | input | 1 | 1 = translate through the tables, 0 = offset passes through |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset |
| req_cpl | input | 2 | Current privilege level |
| req_priv_op | input | 1 | Request is a privileged operation |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | 0 = shared table, 1 = per-process table |
| wr_idx | input | IDX_W | Descriptor index to write |
| wr_base | input | 32 | Base to store |
| wr_limit | input | 32 | Limit to store |
| wr_dpl | input | 2 | Required privilege level to store |
| wr_present | input | 1 | Present flag to store |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_fault | output | 3 | 0 none, 1 privileged op, 2 not present, 3 protection, 4 limit |
| out_lin | output | 32 | Linear address (0 on fault) |

## Verification
The bench aims at the corner cases of each check:
- Offset exactly at the limit and one above it. An off-by-one comparison would fault on a legal access or let an illegal one through.
- A base near the top of the address space. A design that widened or saturated the sum would show up there.
- Cases where only the requested level or only the current level exceeds the required one. Comparing just one of them would wrongly allow an access.
- A privileged operation on a missing descriptor and with translation off. Wrong priority or gating would report the wrong code.
- Same-entry indexes in the two tables, a write in the same cycle as a read, and an out-of-range index. These expose table mix-ups, write forwarding and truncated index decode.

// File: rtl/segx_pkg.sv
package segx_pkg;

  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_PRIVOP  = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_PROT    = 3'd3,
    FLT_LIMIT   = 3'd4
  } fault_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [1:0]        dpl;
    logic              present;
  } desc_t;

  // numerically larger level is the weaker one
  function automatic logic [1:0] weaker_level(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic beyond_limit(input logic [ADDR_W-1:0] off, input logic [ADDR_W-1:0] lim);
    return off > lim;
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ADDR_W-1:0];
  endfunction

endpackage

// File: rtl/segx_desc_table.sv
module segx_desc_table
  import segx_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  desc_t            wr_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output desc_t            rd_desc
);
  localparam int DEPTH = 1 << IDX_W;

  desc_t ent_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        ent_q[e] <= wr_desc;
      end
    end
  end

  assign rd_desc = ent_q[rd_idx];

  // R11: a written entry holds the written value on the next cycle
  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_desc)));

endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
(
  input  logic              seg_en,
  input  logic              priv_op,
  input  logic [1:0]        cpl,
  input  logic [1:0]        rpl,
  input  logic              idx_in_range,
  input  desc_t             desc,
  input  logic [ADDR_W-1:0] off,
  output logic              ev_privop,
  output logic              ev_absent,
  output logic              ev_prot,
  output logic              ev_limit,
  output fault_e            fault,
  output logic [ADDR_W-1:0] lin
);
  assign ev_privop = priv_op && (cpl != 2'd0);
  assign ev_absent = seg_en && (!idx_in_range || !desc.present);
  assign ev_prot   = seg_en && (weaker_level(cpl, rpl) > desc.dpl);
  assign ev_limit  = seg_en && beyond_limit(off, desc.limit);

  always_comb begin
    if (ev_privop)      fault = FLT_PRIVOP;
    else if (ev_absent) fault = FLT_ABSENT;
    else if (ev_prot)   fault = FLT_PROT;
    else if (ev_limit)  fault = FLT_LIMIT;
    else                fault = FLT_NONE;
  end

  always_comb begin
    if (fault != FLT_NONE) lin = '0;
    else if (seg_en)       lin = wrap_add(desc.base, off);
    else                   lin = off;
  end

endmodule

// File: rtl/segx_out_stage.sv
module segx_out_stage
  import segx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  fault_e            in_fault,
  input  logic [ADDR_W-1:0] in_lin,
  output logic              out_valid,
  output logic [2:0]        out_fault,
  output logic [ADDR_W-1:0] out_lin
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 3'd0;
      out_lin   <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid ? in_fault : 3'd0;
      out_lin   <= in_valid ? in_lin : '0;
    end
  end
endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_en,
  input  logic             req_valid,
  input  logic [15:0]      req_sel,
  input  logic [31:0]      req_off,
  input  logic [1:0]       req_cpl,
  input  logic             req_priv_op,
  input  logic             wr_en,
  input  logic             wr_local,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_base,
  input  logic [31:0]      wr_limit,
  input  logic [1:0]       wr_dpl,
  input  logic             wr_present,
  output logic             out_valid,
  output logic [2:0]       out_fault,
  output logic [31:0]      out_lin
);
  localparam int SEL_IDX_W = 13;
  localparam int N_TBL     = 2;

  logic [1:0]           sel_rpl;
  logic                 sel_local;
  logic [SEL_IDX_W-1:0] sel_idx;
  logic                 idx_in_range;
  desc_t                wr_desc;
  desc_t                tbl_rd [N_TBL];
  desc_t                desc_pick;

  assign sel_rpl      = req_sel[1:0];
  assign sel_local    = req_sel[2];
  assign sel_idx      = req_sel[15:3];
  assign idx_in_range = (sel_idx >> IDX_W) == '0;

  assign wr_desc = '{base: wr_base, limit: wr_limit, dpl: wr_dpl, present: wr_present};

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    segx_desc_table #(.IDX_W(IDX_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && (wr_local == 1'(t))),
      .wr_idx  (wr_idx),
      .wr_desc (wr_desc),
      .rd_idx  (sel_idx[IDX_W-1:0]),
      .rd_desc (tbl_rd[t])
    );
  end

  assign desc_pick = sel_local ? tbl_rd[1] : tbl_rd[0];

  logic              ev_privop, ev_absent, ev_prot, ev_limit;
  fault_e            chk_fault;
  logic [ADDR_W-1:0] chk_lin;

  segx_check u_chk (
    .seg_en       (seg_en),
    .priv_op      (req_priv_op),
    .cpl          (req_cpl),
    .rpl          (sel_rpl),
    .idx_in_range (idx_in_range),
    .desc         (desc_pick),
    .off          (req_off),
    .ev_privop    (ev_privop),
    .ev_absent    (ev_absent),
    .ev_prot      (ev_prot),
    .ev_limit     (ev_limit),
    .fault        (chk_fault),
    .lin          (chk_lin)
  );

  segx_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_fault  (chk_fault),
    .in_lin    (chk_lin),
    .out_valid (out_valid),
    .out_fault (out_fault),
    .out_lin   (out_lin)
  );

  // R3: result strobe follows a request by one cycle
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R9: no address escapes with a fault
  a_r9_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fault != 3'd0) |-> (out_lin == '0));
  // R4 / R12: privileged-op trap wins over everything
  a_r4_privop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv_op && req_cpl != 2'd0) |=> (out_fault == 3'd1));
  // R10: pass-through when translation is off
  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seg_en && !(req_priv_op && req_cpl != 2'd0))
      |=> (out_fault == 3'd0 && out_lin == $past(req_off)));
  // R2: an out-of-range index never translates
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_en && !idx_in_range) |=> (out_fault != 3'd0));

endmodule

// File: tb/sim_segx_top.sv
module sim_segx_top;
  localparam int IDX_W = 3;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, seg_en, req_valid, req_priv_op;
  logic [15:0]      req_sel;
  logic [31:0]      req_off;
  logic [1:0]       req_cpl;
  logic             wr_en, wr_local, wr_present;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_base, wr_limit;
  logic [1:0]       wr_dpl;
  logic             out_valid;
  logic [2:0]       out_fault;
  logic [31:0]      out_lin;

  segx_top #(.IDX_W(IDX_W)) u0 (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model of both tables
  logic [31:0] m_base  [2][DEPTH];
  logic [31:0] m_limit [2][DEPTH];
  logic [1:0]  m_dpl   [2][DEPTH];
  logic        m_pres  [2][DEPTH];

  function automatic logic [34:0] model(input logic en, input logic [15:0] sel,
                                        input logic [31:0] off, input logic [1:0] cpl,
                                        input logic pop);
    int t, i;
    logic [1:0] eff;
    t = sel[2];
    i = sel[15:3];
    if (pop && cpl != 0) return {3'd1, 32'd0};
    if (!en) return {3'd0, off};
    if (i >= DEPTH || !m_pres[t][i]) return {3'd2, 32'd0};
    eff = (cpl > sel[1:0]) ? cpl : sel[1:0];
    if (eff > m_dpl[t][i]) return {3'd3, 32'd0};
    if (off > m_limit[t][i]) return {3'd4, 32'd0};
    return {3'd0, 32'(64'(m_base[t][i]) + 64'(off))};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic loc, input int idx, input logic [31:0] b,
                    input logic [31:0] l, input logic [1:0] d, input logic p);
    @(negedge clk);
    wr_en = 1; wr_local = loc; wr_idx = IDX_W'(idx);
    wr_base = b; wr_limit = l; wr_dpl = d; wr_present = p;
    @(negedge clk);
    wr_en = 0;
    m_base[loc][idx] = b; m_limit[loc][idx] = l; m_dpl[loc][idx] = d; m_pres[loc][idx] = p;
  endtask

  task automatic req(input string tag, input logic en, input logic [15:0] sel,
                     input logic [31:0] off, input logic [1:0] cpl, input logic pop);
    logic [34:0] e;
    @(negedge clk);
    e = model(en, sel, off, cpl, pop);
    seg_en = en; req_valid = 1; req_sel = sel; req_off = off; req_cpl = cpl; req_priv_op = pop;
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " fault"}, 64'(out_fault), 64'(e[34:32]));
    check({tag, " lin"},   64'(out_lin),   64'(e[31:0]));
  endtask

  function automatic logic [15:0] mksel(input int idx, input logic loc, input logic [1:0] rpl);
    return {13'(idx), loc, rpl};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DEPTH; i++) begin
        m_base[t][i] = 0; m_limit[t][i] = 0; m_dpl[t][i] = 0; m_pres[t][i] = 0;
      end
    rst_n = 0; seg_en = 1; req_valid = 0; req_sel = 0; req_off = 0; req_cpl = 0;
    req_priv_op = 0; wr_en = 0; wr_local = 0; wr_idx = 0; wr_base = 0; wr_limit = 0;
    wr_dpl = 0; wr_present = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(out_valid), 0);
    check("R1 reset fault", 64'(out_fault), 0);
    check("R1 reset lin",   64'(out_lin),   0);
    rst_n = 1;
    req("R1 empty table", 1, mksel(0, 0, 0), 32'h10, 0, 0);
    @(negedge clk);
    check("R3 idle valid low", 64'(out_valid), 0);

    wr(0, 0, 32'h0001_0000, 32'h1000, 3, 1);
    req("R7 at limit", 1, mksel(0, 0, 3), 32'h1000, 3, 0);
    req("R7 over limit", 1, mksel(0, 0, 0), 32'h1001, 0, 0);
    req("R8 translate", 1, mksel(0, 0, 1), 32'h0123, 2, 0);
    wr(0, 1, 32'hFFFF_F000, 32'hFFFF_FFFF, 0, 1);
    req("R8 wrap", 1, mksel(1, 0, 0), 32'h2000, 0, 0);
    wr(0, 2, 32'h2000_0000, 32'hFFFF, 1, 1);
    req("R6 cpl too weak", 1, mksel(2, 0, 0), 32'h10, 2, 0);
    req("R6 rpl too weak", 1, mksel(2, 0, 2), 32'h10, 0, 0);
    req("R6 equal ok", 1, mksel(2, 0, 1), 32'h10, 1, 0);
    req("R12 prot over limit", 1, mksel(2, 0, 3), 32'h1_0000, 3, 0);
    req("R4 R12 privop on absent", 1, mksel(5, 1, 0), 32'h10, 3, 1);
    req("R4 privop level0 ok", 1, mksel(0, 0, 0), 32'h40, 0, 1);
    req("R4 privop seg off", 0, mksel(0, 0, 0), 32'h40, 1, 1);
    req("R2 index out of range", 1, mksel(DEPTH, 0, 0), 32'h10, 0, 0);
    req("R5 local absent", 1, mksel(0, 1, 0), 32'h10, 0, 0);
    wr(1, 0, 32'h0300_0000, 32'h100, 3, 1);
    req("R11 local table", 1, mksel(0, 1, 0), 32'h20, 0, 0);
    req("R11 global untouched", 1, mksel(0, 0, 0), 32'h20, 0, 0);
    wr(1, 0, 32'h0300_0000, 32'h100, 3, 0);
    req("R5 cleared present", 1, mksel(0, 1, 0), 32'h20, 0, 0);
    req("R10 passthru", 0, mksel(7, 1, 3), 32'hDEAD_BEEF, 3, 0);

    // R11 same-cycle write and request: old entry seen, new entry next
    @(negedge clk);
    begin
      logic [34:0] e_old;
      e_old = model(1, mksel(3, 0, 0), 32'h8, 0, 0);
      wr_en = 1; wr_local = 0; wr_idx = 3; wr_base = 32'h4000; wr_limit = 32'hFF;
      wr_dpl = 0; wr_present = 1;
      seg_en = 1; req_valid = 1; req_sel = mksel(3, 0, 0); req_off = 32'h8; req_cpl = 0; req_priv_op = 0;
      @(negedge clk);
      wr_en = 0; req_valid = 0;
      m_base[0][3] = 32'h4000; m_limit[0][3] = 32'hFF; m_dpl[0][3] = 0; m_pres[0][3] = 1;
      check("R11 same-cycle old fault", 64'(out_fault), 64'(e_old[34:32]));
    end
    req("R11 after write", 1, mksel(3, 0, 0), 32'h8, 0, 0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 4 == 0)
        wr(1'($urandom), int'($urandom % DEPTH), $urandom,
           ($urandom % 2) ? 32'($urandom % 32'h1_0000) : $urandom,
           2'($urandom), ($urandom % 5) != 0);
      req("R8 R12 random", ($urandom % 8) != 0,
          {13'($urandom % (DEPTH + 2)), 1'($urandom), 2'($urandom)},
          ($urandom % 2) ? 32'($urandom % 32'h2_0000) : $urandom,
          2'($urandom), ($urandom % 6) == 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule